// File: doc/BRIEF.md
# Change-Tracking Output Register Wrapper

This block connects a design under test to a simple host register bus when the design runs on hardware and the host steps it. The host writes the design's inputs into input registers, pulses a step through a control register, and reads back the design's outputs from per-port output registers. Each read or write on the bus is one blocking exchange, and one step of the design is one simulation cycle.

To keep host traffic down, every output port has a change detector and a sticky flag. The flags are packed into bus-width words at their own addresses. Per cycle the host reads the flag words first, and then reads only the ports whose flags are set. A cycle with k changed ports therefore costs k plus ceil(N_OUT / DATA_W) reads.

The address map uses word addresses. The N_IN input registers come first, then the N_OUT output registers, then ceil(N_OUT / DATA_W) flag words, and then one control register. Addresses beyond the control register are unmapped.

Top module: `chg_track_wrap`

## Requirements
- R1: After the active-low asynchronous reset, the input registers, output registers and change flags are zero, and the step output is low.
- R2: A write to input address i (0 to N_IN-1) stores the low IN_W bits. They drive slice i of `dut_in_o` from the next cycle, and a read of that address returns them.
- R3: A write to the control register with bit 0 set drives `dut_step_o` high for exactly the one cycle after the write edge. A write with bit 0 clear produces no pulse.
- R4: Output registers capture `dut_out_i` on the second clock edge after the control write, which is one cycle after the step pulse. They hold their value at all other times.
- R5: When a capture stores a value that differs from the port register's previous content, that port's flag is set. An equal capture leaves the flag unchanged. Because the registers reset to zero, any nonzero capture after reset sets the flag.
- R6: A flag stays set across further steps until the host reads that port's output register. That read clears the flag.
- R7: If a capture that sets a port's flag falls on the same edge as a read of that port, the flag ends up set. The read returns the value held before the capture.
- R8: Flag word w, at address N_IN+N_OUT+w, carries port p's flag at bit p mod DATA_W of word p / DATA_W. Bits with no port behind them read zero.
- R9: Writes to output registers, flag words and unmapped addresses change no state.
- R10: Read data appears on `bus_rdata_o` after the clock edge that samples `bus_rd_i`, and holds until the next read. The control register and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Word address of the host access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Registered read data |
| dut_in_o | output | N_IN*IN_W | Input registers, flattened, port 0 in the low bits |
| dut_step_o | output | 1 | One-cycle step pulse to the design under test |
| dut_out_i | input | N_OUT*OUT_W | Design outputs, flattened, port 0 in the low bits |

## Verification
The stand-in design is driven with random sparse change patterns, in which each port changes with low probability. These show that only the ports that really changed raise flags, and that unchanged captures leave flags alone. Several steps without reads separate sticky flags from flags that are rebuilt on every capture. Reads of flagged and unflagged ports separate the per-port clear from a global one. Directed cases cover a port in the second, partly filled flag word, a read landing on the capture edge, a step request with bit 0 clear, and writes to read-only addresses.

// File: rtl/chg_track_pkg.sv
package chg_track_pkg;

  typedef enum logic [2:0] {
    K_IN,
    K_OUT,
    K_FLAG,
    K_CTRL,
    K_NONE
  } addr_kind_e;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/chg_track_decode.sv
module chg_track_decode
  import chg_track_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_IN   = 2,
  parameter int N_OUT  = 6,
  parameter int N_FLW  = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output addr_kind_e        kind_o,
  output logic [ADDR_W-1:0] idx_o
);

  localparam int OUT_BASE  = N_IN;
  localparam int FLG_BASE  = N_IN + N_OUT;
  localparam int CTRL_ADDR = FLG_BASE + N_FLW;

  always_comb begin
    kind_o = K_NONE;
    idx_o  = '0;
    if (addr_i < ADDR_W'(OUT_BASE)) begin
      kind_o = K_IN;
      idx_o  = addr_i;
    end else if (addr_i < ADDR_W'(FLG_BASE)) begin
      kind_o = K_OUT;
      idx_o  = addr_i - ADDR_W'(OUT_BASE);
    end else if (addr_i < ADDR_W'(CTRL_ADDR)) begin
      kind_o = K_FLAG;
      idx_o  = addr_i - ADDR_W'(FLG_BASE);
    end else if (addr_i == ADDR_W'(CTRL_ADDR)) begin
      kind_o = K_CTRL;
    end
  end

endmodule

// File: rtl/chg_track_step.sv
module chg_track_step (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  output logic step_o,
  output logic cap_o
);

  // step pulse, then capture one cycle later once the DUT has advanced
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_o <= 1'b0;
      cap_o  <= 1'b0;
    end else begin
      step_o <= go_i;
      cap_o  <= step_o;
    end
  end

endmodule

// File: rtl/chg_track_oport.sv
module chg_track_oport #(
  parameter int OUT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [OUT_W-1:0] din_i,
  input  logic             clr_i,
  output logic [OUT_W-1:0] q_o,
  output logic             flag_o
);

  logic changed;
  assign changed = cap_i && (din_i != q_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= '0;
      flag_o <= 1'b0;
    end else begin
      if (cap_i) q_o <= din_i;
      // set has priority over the read clear
      if (changed)    flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

endmodule

// File: rtl/chg_track_wrap.sv
module chg_track_wrap
  import chg_track_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_IN   = 2,
  parameter int IN_W   = 16,
  parameter int N_OUT  = 6,
  parameter int OUT_W  = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic                   bus_wr_i,
  input  logic [DATA_W-1:0]      bus_wdata_i,
  input  logic                   bus_rd_i,
  output logic [DATA_W-1:0]      bus_rdata_o,
  output logic [N_IN*IN_W-1:0]   dut_in_o,
  output logic                   dut_step_o,
  input  logic [N_OUT*OUT_W-1:0] dut_out_i
);

  localparam int N_FLW = ceil_div(N_OUT, DATA_W);
  localparam int FLG_W = N_FLW * DATA_W;

  addr_kind_e          kind;
  logic [ADDR_W-1:0]   idx;
  logic                cap;
  logic                go;
  logic [N_OUT-1:0]    flags;
  logic [N_OUT-1:0]    clr;
  logic [FLG_W-1:0]    flag_pad;
  logic [OUT_W-1:0]    out_q [N_OUT];
  logic [N_OUT*OUT_W-1:0] out_q_flat;
  logic [IN_W-1:0]     in_q [N_IN];
  logic [DATA_W-1:0]   rd_mux;

  chg_track_decode #(
    .ADDR_W(ADDR_W), .N_IN(N_IN), .N_OUT(N_OUT), .N_FLW(N_FLW)
  ) u_dec (
    .addr_i(bus_addr_i),
    .kind_o(kind),
    .idx_o (idx)
  );

  assign go = bus_wr_i && (kind == K_CTRL) && bus_wdata_i[0];

  chg_track_step u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .go_i  (go),
    .step_o(dut_step_o),
    .cap_o (cap)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) in_q[i] <= '0;
      else if (bus_wr_i && kind == K_IN && idx == ADDR_W'(i))
        in_q[i] <= bus_wdata_i[IN_W-1:0];
    end
    assign dut_in_o[i*IN_W +: IN_W] = in_q[i];
  end

  for (genvar p = 0; p < N_OUT; p++) begin : g_out
    assign clr[p] = bus_rd_i && kind == K_OUT && idx == ADDR_W'(p);
    chg_track_oport #(.OUT_W(OUT_W)) u_port (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cap_i (cap),
      .din_i (dut_out_i[p*OUT_W +: OUT_W]),
      .clr_i (clr[p]),
      .q_o   (out_q[p]),
      .flag_o(flags[p])
    );
    assign out_q_flat[p*OUT_W +: OUT_W] = out_q[p];
  end

  assign flag_pad = FLG_W'(flags);

  always_comb begin
    rd_mux = '0;
    unique case (kind)
      K_IN:
        for (int i = 0; i < N_IN; i++)
          if (idx == ADDR_W'(i)) rd_mux = DATA_W'(in_q[i]);
      K_OUT:
        for (int p = 0; p < N_OUT; p++)
          if (idx == ADDR_W'(p)) rd_mux = DATA_W'(out_q[p]);
      K_FLAG:
        for (int w = 0; w < N_FLW; w++)
          if (idx == ADDR_W'(w)) rd_mux = flag_pad[w*DATA_W +: DATA_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_mux;
  end

endmodule

// File: rtl/chg_track_wrap_chk.sv
module chg_track_wrap_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_IN   = 2,
  parameter int N_OUT  = 6,
  parameter int OUT_W  = 12
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      bus_addr_i,
  input logic                   bus_wr_i,
  input logic                   bus_wdata_b0_i,
  input logic                   bus_rd_i,
  input logic [DATA_W-1:0]      bus_rdata_o,
  input logic                   dut_step_o,
  input logic                   cap_i,
  input logic [N_OUT-1:0]       flags_i,
  input logic [N_OUT*OUT_W-1:0] outq_i
);

  localparam int N_FLW     = (N_OUT + DATA_W - 1) / DATA_W;
  localparam int CTRL_ADDR = N_IN + N_OUT + N_FLW;

  a_r3_step_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dut_step_o |=> !dut_step_o);

  a_r3_step_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dut_step_o) |-> $past(bus_wr_i && bus_addr_i == ADDR_W'(CTRL_ADDR) && bus_wdata_b0_i));

  a_r4_hold_outside_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(outq_i));

  a_r5_set_needs_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_i & ~$past(flags_i))) |-> $past(cap_i));

  a_r6_clear_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~flags_i & $past(flags_i))) |-> $past(bus_rd_i));

  a_r10_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i >= ADDR_W'(CTRL_ADDR)) |=> bus_rdata_o == '0);

endmodule

bind chg_track_wrap chg_track_wrap_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_IN(N_IN), .N_OUT(N_OUT), .OUT_W(OUT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_addr_i    (bus_addr_i),
  .bus_wr_i      (bus_wr_i),
  .bus_wdata_b0_i(bus_wdata_i[0]),
  .bus_rd_i      (bus_rd_i),
  .bus_rdata_o   (bus_rdata_o),
  .dut_step_o    (dut_step_o),
  .cap_i         (cap),
  .flags_i       (flags),
  .outq_i        (out_q_flat)
);

// File: tb/chg_track_wrap_bench.sv
module chg_track_wrap_bench;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int N_IN   = 2;
  localparam int IN_W   = 16;
  localparam int N_OUT  = 40;
  localparam int OUT_W  = 12;
  localparam int N_FLW  = 2;
  localparam int OUT_A  = N_IN;
  localparam int FLG_A  = N_IN + N_OUT;
  localparam int CTRL_A = FLG_A + N_FLW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [N_IN*IN_W-1:0] din;
  logic step;
  logic [N_OUT*OUT_W-1:0] dout;

  logic [OUT_W-1:0] dut_nxt [N_OUT];
  logic [OUT_W-1:0] dut_cur [N_OUT];
  logic [OUT_W-1:0] exp_reg [N_OUT];
  bit               exp_flag[N_OUT];
  logic [IN_W-1:0]  exp_in  [N_IN];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chg_track_wrap #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_IN(N_IN), .IN_W(IN_W),
    .N_OUT(N_OUT), .OUT_W(OUT_W)
  ) u_chg_track_wrap (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rd_i(rd), .bus_rdata_o(rdata),
    .dut_in_o(din), .dut_step_o(step), .dut_out_i(dout)
  );

  // stand-in DUT: advances to the preset next values on a step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int p = 0; p < N_OUT; p++) dut_cur[p] <= '0;
    else if (step) for (int p = 0; p < N_OUT; p++) dut_cur[p] <= dut_nxt[p];
  end
  always_comb for (int p = 0; p < N_OUT; p++) dout[p*OUT_W +: OUT_W] = dut_cur[p];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] flag_word(int w);
    logic [31:0] r = '0;
    for (int b = 0; b < DATA_W; b++)
      if (w*DATA_W + b < N_OUT) r[b] = exp_flag[w*DATA_W + b];
    return r;
  endfunction

  task automatic hwrite(int a, logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic hread(int a, output logic [31:0] d);
    addr = ADDR_W'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
    if (a >= OUT_A && a < FLG_A) exp_flag[a-OUT_A] = 0;
  endtask

  task automatic model_step();
    for (int p = 0; p < N_OUT; p++) begin
      if (dut_nxt[p] != exp_reg[p]) exp_flag[p] = 1;
      exp_reg[p] = dut_nxt[p];
    end
  endtask

  task automatic do_step(bit go);
    hwrite(CTRL_A, {$urandom() & 32'hFFFF_FFFE} | {31'd0, go});
    chk("R3 step pulse", {31'd0, step}, {31'd0, go});
    @(negedge clk);
    chk("R3 step width", {31'd0, step}, 32'd0);
    @(negedge clk);
    if (go) model_step();
  endtask

  task automatic check_flags(string req);
    logic [31:0] d;
    for (int w = 0; w < N_FLW; w++) begin
      hread(FLG_A + w, d);
      chk(req, d, flag_word(w));
    end
  endtask

  task automatic read_port(int p, string req);
    logic [31:0] d;
    hread(OUT_A + p, d);
    chk(req, d, {20'd0, exp_reg[p]});
  endtask

  task automatic shuffle(int prob);
    for (int p = 0; p < N_OUT; p++) begin
      dut_nxt[p] = exp_reg[p];
      if (($urandom() % 100) < prob)
        dut_nxt[p] = exp_reg[p] ^ OUT_W'(($urandom() % 4095) + 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, old;
    void'($urandom(32'd2024));
    for (int p = 0; p < N_OUT; p++) begin
      dut_nxt[p] = '0; exp_reg[p] = '0; exp_flag[p] = 0;
    end
    for (int i = 0; i < N_IN; i++) exp_in[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 step low", {31'd0, step}, 32'd0);
    chk("R1 inputs zero", din, 32'd0);
    read_port(0, "R1 port zero");
    check_flags("R1 flags zero");

    // R2 input registers
    for (int i = 0; i < N_IN; i++) begin
      d = $urandom();
      hwrite(i, d);
      exp_in[i] = d[IN_W-1:0];
    end
    chk("R2 drive", din, {exp_in[1], exp_in[0]});
    for (int i = 0; i < N_IN; i++) begin
      hread(i, d);
      chk("R2 readback", d, {16'd0, exp_in[i]});
    end

    // R3 control write with bit 0 clear: no step, no capture
    shuffle(100);
    do_step(0);
    check_flags("R3 no step no flags");
    read_port(5, "R3 port unchanged");

    // R5 first step after reset: nonzero sets flags
    do_step(1);
    check_flags("R5 first capture");

    // random sparse patterns
    for (int it = 0; it < 40; it++) begin
      int nsteps = 1 + ($urandom() % 2);
      for (int s = 0; s < nsteps; s++) begin
        shuffle(15);
        do_step(1);
      end
      check_flags("R6 R8 sticky flags");
      for (int p = 0; p < N_OUT; p++)
        if (exp_flag[p]) read_port(p, "R4 captured value");
      read_port($urandom() % N_OUT, "R4 unflagged value");
      check_flags("R6 cleared by read");
      // unchanged capture keeps flags clear
      shuffle(0);
      do_step(1);
      check_flags("R5 equal capture no flag");
    end

    // R8 last port in the partly filled second word
    shuffle(0);
    dut_nxt[N_OUT-1] = exp_reg[N_OUT-1] ^ 12'h5A5;
    do_step(1);
    hread(FLG_A + 1, d);
    chk("R8 port 39 bit 7 word 1", d, 32'h0000_0080);
    read_port(N_OUT-1, "R8 port 39 value");

    // R7 read on the capture edge: set wins, read returns old value
    shuffle(0);
    dut_nxt[3] = exp_reg[3] ^ 12'h00F;
    hwrite(CTRL_A, 32'd1);
    @(negedge clk);
    old = {20'd0, exp_reg[3]};
    addr = ADDR_W'(OUT_A + 3); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk("R7 read returns pre-capture", rdata, old);
    model_step();
    check_flags("R7 set wins over clear");
    read_port(3, "R7 new value");

    // R9 writes to read-only addresses
    shuffle(0);
    dut_nxt[2] = exp_reg[2] ^ 12'h800;
    do_step(1);
    hwrite(OUT_A + 2, 32'hFFFF_FFFF);
    hwrite(FLG_A, 32'h0);
    hwrite(FLG_A + 1, 32'hFFFF_FFFF);
    hwrite(CTRL_A + 5, 32'hFFFF_FFFF);
    chk("R9 no step from unmapped", {31'd0, step}, 32'd0);
    check_flags("R9 flags untouched");
    read_port(2, "R9 port untouched");
    chk("R9 inputs untouched", din, {exp_in[1], exp_in[0]});

    // R10 control and unmapped read zero, data holds
    hread(CTRL_A, d);
    chk("R10 control reads zero", d, 32'd0);
    hread(0, d);
    hread(CTRL_A + 9, d);
    chk("R10 unmapped reads zero", d, 32'd0);
    hread(1, d);
    @(negedge clk);
    chk("R10 data holds", rdata, {16'd0, exp_in[1]});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule